// File: doc/BRIEF.md
# SPI Serial Byte Memory Slave

This block is the slave side of a serial memory reached over a four-wire SPI link plus a hold input and a write-protect input. A host selects the slave with chip select, clocks in an 8-bit command, and then, depending on the command, a 16-bit address followed by any number of data bytes, or a single status byte. The storage is an on-chip byte array. Each written byte lands in the array on its last bit, so there is no busy period and no polling. A sequential address counter lets one address open an unbounded stream of bytes in either direction.

The serial pins are oversampled by a fast system clock. Each pin passes through a two-stage synchronizer, and the SCK edges are then detected in the system clock domain. SCK must therefore stay at each level for at least three system clocks. The serial output is given as a data bit and an output enable, and the pad tri-state sits outside the block. A small status register holds the write-enable latch and a protect-enable bit, and the protect-enable bit can lock the status register while the write-protect pin is low.

Top module: `spi_mem_slave`

## Requirements
- R1: Both SCK idle polarities (mode 0, idle low; mode 3, idle high) work unchanged: SI is sampled on rising SCK edges and SO changes only on falling SCK edges.
- R2: Every command, address and data unit is 8 bits, transferred most significant bit first on SI and on SO.
- R3: The address is sent as two bytes (high byte first). Only the low AW bits (default 11, i.e. 2048 bytes; 15 gives 32768) select a byte, and the upper bits are ignored.
- R4: Command 0x06 sets the write-enable latch (status bit 1), and command 0x04 clears it. Data sent after write command 0x02 changes no array byte while the latch is clear.
- R5: Command 0x05 makes the slave return the status byte: bit 7 is protect-enable, bit 1 is the write-enable latch, and all other bits are zero.
- R6: Command 0x03 followed by an address returns the stored bytes. A written byte is in the array as soon as its eighth bit is sampled and can be read back in the very next frame.
- R7: After every data byte, in reads and in writes, the address advances by one and wraps from 2^AW-1 to 0.
- R8: While hold_ni is low, SCK edges are ignored and so_oe_o is 0. After hold_ni returns high, the transfer continues from the bit where it paused.
- R9: Raising cs_ni ends the command, discards a partial byte, returns the decoder to command state and drops so_oe_o. After reset so_oe_o is 0.
- R10: The write-enable latch clears when cs_ni rises after a 0x02 or 0x01 command.
- R11: Command 0x01, with the latch set, loads protect-enable from bit 7 of the next byte. When protect-enable is 1 and wp_ni is low, the load is blocked.
- R12: Any other opcode is ignored until cs_ni rises: no output is enabled and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the host |
| si_i | input | 1 | Serial data into the slave |
| so_o | output | 1 | Serial data out of the slave |
| so_oe_o | output | 1 | Output enable for so_o; 0 means high impedance |
| wp_ni | input | 1 | Write-protect pin, active low |
| hold_ni | input | 1 | Hold pin, active low; pauses the transfer |

## Verification
Two things can land in the same system-clock cycle: a rising SCK edge and the start of a hold. Both pins pass through identical synchronizers, so the bench forces the collision by moving hold_ni low at the same instant that SCK rises in the middle of a write data byte. It then toggles SCK while hold is low, releases hold and sends that bit again. The check is that the byte read back afterwards equals the intended value, so the colliding edge and the edges during hold were dropped and not counted as bits. A second collision case is a hold during a read, where so_oe_o must be 0 while paused and the byte must still arrive intact.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR_HI, ST_ADDR_LO, ST_READ,
    ST_WRITE, ST_STAT_OUT, ST_STAT_IN, ST_IGNORE
  } cmd_state_e;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_mem_shift.sv
module spi_mem_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       hold_i,
  input  logic       sck_i,
  input  logic       si_i,
  input  logic [7:0] tx_data_i,
  output logic       so_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o
);
  logic       sck_q;
  logic [2:0] bit_cnt_q;
  logic [6:0] rx_sh_q;
  logic [7:0] tx_sh_q;
  logic       active, sck_rise, sck_fall;

  // edges only count while selected and not held
  assign active   = sel_i && hold_i;
  assign sck_rise = active &&  sck_i && !sck_q;
  assign sck_fall = active && !sck_i &&  sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q       <= 1'b0;
      bit_cnt_q   <= '0;
      rx_sh_q     <= '0;
      rx_byte_o   <= '0;
      byte_done_o <= 1'b0;
      tx_sh_q     <= '0;
    end else begin
      sck_q       <= sck_i;
      byte_done_o <= 1'b0;
      if (!sel_i) begin
        bit_cnt_q <= '0;
      end else begin
        if (sck_rise) begin
          rx_sh_q   <= {rx_sh_q[5:0], si_i};
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            rx_byte_o   <= {rx_sh_q, si_i};
            byte_done_o <= 1'b1;
          end
        end
        if (sck_fall) begin
          if (bit_cnt_q == 3'd0) tx_sh_q <= tx_data_i;
          else                   tx_sh_q <= {tx_sh_q[6:0], 1'b0};
        end
      end
    end
  end

  assign so_o = tx_sh_q[7];

  assert_cs_resets_bits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (bit_cnt_q == 3'd0) && !byte_done_o);

  assert_hold_freezes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !hold_i) |=> $stable(bit_cnt_q) && $stable(rx_sh_q) && $stable(tx_sh_q));

  assert_byte_on_eighth_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> (bit_cnt_q == 3'd0));
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wp_i,
  input  logic          byte_done_i,
  input  logic [7:0]    rx_byte_i,
  input  logic [7:0]    rd_data_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    tx_data_o,
  output logic          drive_o
);
  localparam int unsigned HI_W = AW - 8;

  cmd_state_e    state_q;
  logic [HI_W-1:0] addr_hi_q;
  logic [AW-1:0] addr_q;
  logic          wel_q, wpen_q, clr_pend_q;
  logic [7:0]    status;

  assign status     = {wpen_q, 5'b0, wel_q, 1'b0};
  assign mem_we_o   = sel_i && byte_done_i && (state_q == ST_WRITE) && wel_q;
  assign mem_addr_o = addr_q;
  assign tx_data_o  = (state_q == ST_STAT_OUT) ? status : rd_data_i;
  assign drive_o    = (state_q == ST_READ) || (state_q == ST_STAT_OUT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_CMD;
      addr_hi_q  <= '0;
      addr_q     <= '0;
      wel_q      <= 1'b0;
      wpen_q     <= 1'b0;
      clr_pend_q <= 1'b0;
    end else if (!sel_i) begin
      state_q <= ST_CMD;
      if (clr_pend_q) begin
        wel_q      <= 1'b0;
        clr_pend_q <= 1'b0;
      end
    end else if (byte_done_i) begin
      unique case (state_q)
        ST_CMD: begin
          unique case (rx_byte_i)
            OP_WREN: begin wel_q <= 1'b1; state_q <= ST_IGNORE; end
            OP_WRDI: begin wel_q <= 1'b0; state_q <= ST_IGNORE; end
            OP_RDSR: state_q <= ST_STAT_OUT;
            OP_WRSR: begin
              clr_pend_q <= 1'b1;
              state_q    <= wel_q ? ST_STAT_IN : ST_IGNORE;
            end
            OP_READ: state_q <= ST_ADDR_HI;
            OP_WRIT: begin clr_pend_q <= 1'b1; state_q <= ST_ADDR_HI; end
            default: state_q <= ST_IGNORE;
          endcase
        end
        ST_ADDR_HI: begin
          addr_hi_q <= rx_byte_i[HI_W-1:0];
          state_q   <= ST_ADDR_LO;
        end
        ST_ADDR_LO: begin
          addr_q  <= {addr_hi_q, rx_byte_i};
          // opcode kind kept in clr_pend_q: set only for writes
          state_q <= clr_pend_q ? ST_WRITE : ST_READ;
        end
        ST_READ, ST_WRITE: addr_q <= addr_q + AW'(1);
        ST_STAT_IN: begin
          if (!(wpen_q && !wp_i)) wpen_q <= rx_byte_i[7];
          state_q <= ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  assert_wel_from_wren_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(sel_i && byte_done_i && state_q == ST_CMD && rx_byte_i == OP_WREN));

  assert_addr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && byte_done_i && (state_q == ST_READ || state_q == ST_WRITE))
      |=> addr_q == $past(addr_q) + AW'(1));

  assert_wpen_locked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wpen_q && !wp_i) |=> wpen_q);

  assert_wel_clear_on_deselect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && clr_pend_q) |=> !wel_q);
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int unsigned AW = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic so_o,
  output logic so_oe_o,
  input  logic wp_ni,
  input  logic hold_ni
);
  logic [4:0]    pins_s;
  logic          cs_s, hold_s, wp_s, sck_s, si_s, sel;
  logic          byte_done, mem_we, drive;
  logic [7:0]    rx_byte, rd_data, tx_data;
  logic [AW-1:0] mem_addr;

  spi_mem_sync #(.W(5), .RST_VAL(5'b11100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, hold_ni, wp_ni, sck_i, si_i}),
    .q_o   (pins_s)
  );
  assign {cs_s, hold_s, wp_s, sck_s, si_s} = pins_s;
  assign sel = !cs_s;

  spi_mem_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .hold_i     (hold_s),
    .sck_i      (sck_s),
    .si_i       (si_s),
    .tx_data_i  (tx_data),
    .so_o       (so_o),
    .byte_done_o(byte_done),
    .rx_byte_o  (rx_byte)
  );

  spi_mem_ctrl #(.AW(AW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .wp_i       (wp_s),
    .byte_done_i(byte_done),
    .rx_byte_i  (rx_byte),
    .rd_data_i  (rd_data),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_addr),
    .tx_data_o  (tx_data),
    .drive_o    (drive)
  );

  spi_mem_array #(.AW(AW)) u_array (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .addr_i (mem_addr),
    .wdata_i(rx_byte),
    .rdata_o(rd_data)
  );

  assign so_oe_o = sel && hold_s && drive;

  assert_no_write_unselected_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> sel && $past(sel));
endmodule

// File: tb/spi_mem_slave_test.sv
`timescale 1ns/1ps
module spi_mem_slave_test;
  localparam int HPC = 4;  // SCK half period in system clocks

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
  logic so, so_oe;
  logic mode3 = 1'b0;
  logic oe_seen;
  logic done = 1'b0;
  int   checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_mem_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .wp_ni(wp_n), .hold_ni(hold_n)
  );

  // {address, data, mode3 for the write}
  localparam logic [24:0] VEC [8] = '{
    {16'h0000, 8'hA5, 1'b0}, {16'h0001, 8'h3C, 1'b1},
    {16'h0123, 8'hFF, 1'b0}, {16'h0400, 8'h81, 1'b1},
    {16'h0255, 8'h7E, 1'b0}, {16'h0100, 8'hC3, 1'b1},
    {16'h06AA, 8'h5A, 1'b0}, {16'h0777, 8'h01, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_hp();
    repeat (HPC) @(negedge clk);
  endtask

  task automatic begin_frame(input logic m3);
    mode3  = m3;
    sck    = m3;
    wait_hp();
    cs_n   = 1'b0;
    oe_seen = 1'b0;
    wait_hp();
  endtask

  task automatic end_frame();
    if (!mode3) sck = 1'b0;
    wait_hp();
    cs_n = 1'b1;
    wait_hp();
    wait_hp();
  endtask

  // hold_at: pause before that bit; coin_at: hold falls with a rising edge
  task automatic xfer(input logic [7:0] tx, input int hold_at, input int coin_at,
                      output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      si  = tx[i];
      wait_hp();
      if (i == coin_at) begin
        sck = 1'b1; hold_n = 1'b0; wait_hp();
        sck = 1'b0; wait_hp();
        hold_n = 1'b1; wait_hp();
      end
      if (i == hold_at) begin
        hold_n = 1'b0; wait_hp();
        chk("R8 oe during hold", {7'b0, so_oe}, 8'h00);
        sck = 1'b1; wait_hp();
        sck = 1'b0; wait_hp();
        hold_n = 1'b1; wait_hp();
      end
      rx[i] = so;
      if (so_oe) oe_seen = 1'b1;
      sck = 1'b1;
      wait_hp();
    end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d;
    xfer(b, -1, -1, d);
  endtask

  task automatic cmd_only(input logic [7:0] op);
    begin_frame(mode3);
    send(op);
    end_frame();
  endtask

  task automatic rd_status(output logic [7:0] s);
    begin_frame(mode3);
    send(8'h05);
    xfer(8'h00, -1, -1, s);
    end_frame();
  endtask

  task automatic write_seq(input logic [15:0] a, input logic [7:0] d0, d1, d2,
                           input int n, input int coin_at);
    logic [7:0] d;
    begin_frame(mode3);
    send(8'h02);
    send(a[15:8]);
    send(a[7:0]);
    xfer(d0, -1, coin_at, d);
    if (n > 1) send(d1);
    if (n > 2) send(d2);
    end_frame();
  endtask

  task automatic read_seq(input logic [15:0] a, input int n, input int hold_at,
                          output logic [7:0] r0, r1, r2);
    begin_frame(mode3);
    send(8'h03);
    send(a[15:8]);
    send(a[7:0]);
    xfer(8'h00, hold_at, -1, r0);
    r1 = 8'h00; r2 = 8'h00;
    if (n > 1) xfer(8'h00, -1, -1, r1);
    if (n > 2) xfer(8'h00, -1, -1, r2);
    end_frame();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, r0, r1, r2;
    repeat (4) @(negedge clk);
    chk("R9 oe in reset", {7'b0, so_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 oe after reset", {7'b0, so_oe}, 8'h00);

    // table: write in one mode, read back in the other (R1 R2 R6)
    for (int k = 0; k < 8; k++) begin
      mode3 = VEC[k][0];
      cmd_only(8'h06);
      write_seq(VEC[k][24:9], VEC[k][8:1], 8'h00, 8'h00, 1, -1);
      mode3 = ~VEC[k][0];
      read_seq(VEC[k][24:9], 1, -1, r0, r1, r2);
      chk("R1 R2 R6 table readback", r0, VEC[k][8:1]);
    end

    mode3 = 1'b0;
    // R4 R5: latch visible in status; R10 cleared after write frame
    cmd_only(8'h06);
    rd_status(s);
    chk("R5 status after wren", s, 8'h02);
    write_seq(16'h0010, 8'h44, 8'h00, 8'h00, 1, -1);
    rd_status(s);
    chk("R10 latch cleared", s, 8'h00);

    // R4: write without latch ignored
    write_seq(16'h0123, 8'h11, 8'h00, 8'h00, 1, -1);
    read_seq(16'h0123, 1, -1, r0, r1, r2);
    chk("R4 write without latch", r0, 8'hFF);

    // R4: 0x04 clears the latch
    cmd_only(8'h06);
    cmd_only(8'h04);
    rd_status(s);
    chk("R4 wrdi clears latch", s, 8'h00);

    // R7: sequential write across top of array, wrap to 0
    mode3 = 1'b1;
    cmd_only(8'h06);
    write_seq(16'h07FE, 8'h12, 8'h34, 8'h56, 3, -1);
    read_seq(16'h07FE, 3, -1, r0, r1, r2);
    chk("R7 seq byte 0", r0, 8'h12);
    chk("R7 seq byte 1", r1, 8'h34);
    chk("R7 wrapped byte", r2, 8'h56);

    // R3: upper address bits ignored
    read_seq(16'hF923, 1, -1, r0, r1, r2);
    chk("R3 upper bits ignored", r0, 8'hFF);

    // R12: unknown opcode, no output, no state change
    mode3 = 1'b0;
    begin_frame(1'b0);
    send(8'hAB);
    send(8'h06);
    send(8'h00);
    end_frame();
    chk("R12 no oe on unknown", {7'b0, oe_seen}, 8'h00);
    rd_status(s);
    chk("R12 status untouched", s, 8'h00);

    // R11: status write, then blocked by wp_ni low
    cmd_only(8'h06);
    begin_frame(1'b0); send(8'h01); send(8'h80); end_frame();
    rd_status(s);
    chk("R11 wpen set", s, 8'h80);
    wp_n = 1'b0;
    cmd_only(8'h06);
    begin_frame(1'b0); send(8'h01); send(8'h00); end_frame();
    rd_status(s);
    chk("R11 blocked under wp", s, 8'h80);
    wp_n = 1'b1;
    cmd_only(8'h06);
    begin_frame(1'b0); send(8'h01); send(8'h00); end_frame();
    rd_status(s);
    chk("R11 cleared with wp high", s, 8'h00);

    // R8: hold collides with a rising edge mid write byte
    cmd_only(8'h06);
    write_seq(16'h0200, 8'hB6, 8'h00, 8'h00, 1, 3);
    read_seq(16'h0200, 1, -1, r0, r1, r2);
    chk("R8 hold on rising edge", r0, 8'hB6);

    // R8: hold during read output
    mode3 = 1'b1;
    read_seq(16'h0200, 1, 4, r0, r1, r2);
    chk("R8 read across hold", r0, 8'hB6);

    // R9: partial byte dropped when cs_ni rises
    cmd_only(8'h06);
    begin_frame(1'b1);
    send(8'h02); send(8'h00); send(8'h01);
    for (int i = 7; i >= 4; i--) begin
      sck = 1'b0; si = 1'b0; wait_hp();
      sck = 1'b1; wait_hp();
    end
    end_frame();
    chk("R9 oe after deselect", {7'b0, so_oe}, 8'h00);
    read_seq(16'h0001, 1, -1, r0, r1, r2);
    chk("R9 partial byte dropped", r0, 8'h3C);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule